// File: doc/BRIEF.md
# Five-Port Wormhole Route-Setup Switch

This block is the message switch of one tile in a mesh. It has four neighbour ports (north, east, west, south) and one local port that faces the tile's configurable logic region. Every input port and every output port carries a 5-bit symbol under a four-phase request/acknowledge handshake. The sender raises request with the symbol held stable. The receiver raises acknowledge. The sender drops request, and then the receiver drops acknowledge.

A message builds its own path one hop at a time. The first direction command that an idle input receives claims the matching output through that output's locking arbiter and is consumed. From then on, every symbol on that input is passed through to the claimed output, including further direction commands, which the next tile will use. The path stays in place across any number of messages. It is torn down only when a clear command travels through it: the clear is delivered downstream first, and the output lock is dropped after that handshake has fully returned to zero. Inputs that route to different outputs work at the same time. An input that asks for an output held by another input stalls with its acknowledge low.

The handshakes are modelled as clocked logic. Every request and acknowledge is sampled on the rising clock edge.

Top module: `wh_switch`

## Requirements
- R1: After reset every in_ack and out_req bit is low and no input holds a route.
- R2: Port index is north 0, east 1, west 2, south 3, local 4. A symbol with bit 4 set is a command with its code in bits 3:0: codes 0 to 4 route to the port of that index, code 5 is clear, and other codes are plain commands. A symbol with bit 4 clear is a data nibble.
- R3: An unrouted input given a direction command for a free output locks that output and consumes the command (nothing appears on any output). Its in_ack rises on the second clock edge after in_req rises.
- R4: On a routed input, each symbol appears with out_req on the chosen output one edge after in_req rises. in_ack rises one edge after that output's out_ack is seen, and in_ack stays high until both in_req and out_ack are low.
- R5: A direction command arriving on an input that already holds a route is forwarded unchanged as payload and does not alter the route.
- R6: A clear command on a routed input is forwarded downstream first. The route and the output lock are released when that handshake completes, so the next symbol on the input is treated as unrouted and another input can claim the output.
- R7: A route persists across any number of forwarded symbols until a clear command passes.
- R8: Inputs routed to different outputs forward at the same time with the same latency, and each output is driven by at most one input.
- R9: An input requesting an output held by another input keeps in_ack low until the holder's clear completes. It then gets the lock and acknowledges two edges after the release.
- R10: When several unrouted inputs request the same free output on the same edge, the lowest-indexed input wins and the others stall.
- R11: Any non-direction symbol (data, clear or plain command) on an unrouted input is consumed with in_ack rising one edge after in_req rises, and nothing is forwarded.
- R12: While a downstream receiver holds out_ack low, out_req stays high and the routed input keeps in_ack low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_req | input | NPORT | Request per input port |
| in_sym | input | NPORT*SYM_W | Input symbols; port p occupies bits p*SYM_W upward |
| in_ack | output | NPORT | Acknowledge per input port |
| out_req | output | NPORT | Request per output port |
| out_sym | output | NPORT*SYM_W | Output symbols, same packing as in_sym |
| out_ack | input | NPORT | Acknowledge per output port from downstream |

## Verification
The latency of each result is fixed. A forwarded symbol raises out_req one edge after in_req. With a receiver that answers at once, the input's acknowledge comes two edges after request. A setup command is acknowledged after two edges and an unrouted consumed symbol after one. A stalled claimant acknowledges exactly two edges after the holder's release edge. The bench drives and samples only on falling edges and counts those edges from the request until the acknowledge is seen, so it compares exact counts: 2, 2, 1, 9 for the priority loser and 11 for the stalled waiter. The forwarded symbols are captured by a bench receiver at the falling edge where out_req is first seen, and their value and count are compared.

// File: rtl/wh_pkg.sv
// Shared types for the wormhole switch.
// Assumes: port index equals the direction command code.
package wh_pkg;
    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,   // waiting for a new symbol
        PS_FWD  = 2'd1,   // symbol offered downstream
        PS_DONE = 2'd2    // acknowledging, waiting for return to zero
    } port_state_e;
endpackage

// File: rtl/wh_out_lock.sv
// Locking arbiter for one output port.
// When free, it grants the lowest-indexed requester and keeps that grant
// until the owner raises its release bit.
// Assumes: requests are levels held until granted.
module wh_out_lock #(
    parameter int NPORT = 5,
    localparam int IDX_W = $clog2(NPORT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPORT-1:0] req,
    input  logic [NPORT-1:0] rel,
    output logic [NPORT-1:0] grant,
    output logic             locked
);
    logic             locked_q;
    logic [IDX_W-1:0] owner_q;
    logic [IDX_W-1:0] pick;
    logic             any_req;
    logic             owner_rel;

    // lowest-index requester
    always_comb begin
        pick    = '0;
        any_req = |req;
        for (int k = NPORT - 1; k >= 0; k--) begin
            if (req[k]) pick = IDX_W'(k);
        end
    end

    // release bit of the current owner
    always_comb begin
        owner_rel = 1'b0;
        for (int k = 0; k < NPORT; k++) begin
            if (owner_q == IDX_W'(k) && rel[k]) owner_rel = 1'b1;
        end
    end

    // lock state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_q <= 1'b0;
            owner_q  <= '0;
        end else if (locked_q) begin
            if (owner_rel) locked_q <= 1'b0;
        end else if (any_req) begin
            locked_q <= 1'b1;
            owner_q  <= pick;
        end
    end

    // one-hot grant to owner
    always_comb begin
        for (int k = 0; k < NPORT; k++) begin
            grant[k] = locked_q && (owner_q == IDX_W'(k));
        end
    end

    assign locked = locked_q;

    p_lock_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_q && !owner_rel) |=> (locked_q && $stable(owner_q)));

    p_lock_from_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_q) |-> $past(any_req));
endmodule

// File: rtl/wh_in_port.sv
// Input port controller.
// It consumes the first direction command to claim an output. After that
// it forwards every symbol to the claimed output, and it releases the
// route once a forwarded clear command has fully handshaken downstream.
// Assumes: the sender holds in_sym stable while in_req is high.
module wh_in_port #(
    parameter int NPORT = 5,
    parameter int SYM_W = 5,
    localparam int IDX_W  = $clog2(NPORT),
    localparam int CODE_W = SYM_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_req,
    input  logic [SYM_W-1:0] in_sym,
    output logic             in_ack,
    input  logic [NPORT-1:0] grant,
    input  logic             dest_ack,
    output logic [NPORT-1:0] claim,
    output logic             fwd_valid,
    output logic [IDX_W-1:0] route_dst,
    output logic             release_o
);
    import wh_pkg::*;

    port_state_e      state_q;
    logic             routed_q;
    logic             clr_q;
    logic             fwd_q;
    logic [IDX_W-1:0] dst_q;

    logic              is_cmd, is_dir, is_clr, granted, done_ok;
    logic [CODE_W-1:0] code;

    // symbol decode
    always_comb begin
        is_cmd = in_sym[SYM_W-1];
        code   = in_sym[CODE_W-1:0];
        is_dir = is_cmd && (code < CODE_W'(NPORT));
        is_clr = is_cmd && (code == CODE_W'(NPORT));
    end

    // claim toward arbiters while unrouted and offered a direction
    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            claim[p] = (state_q == PS_IDLE) && in_req && !routed_q
                       && is_dir && (code == CODE_W'(p));
        end
        granted = |(claim & grant);
    end

    // handshake return-to-zero condition
    assign done_ok   = !in_req && !(fwd_q && dest_ack);
    assign release_o = (state_q == PS_DONE) && clr_q && done_ok;

    // port state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= PS_IDLE;
            routed_q <= 1'b0;
            clr_q    <= 1'b0;
            fwd_q    <= 1'b0;
            dst_q    <= '0;
        end else begin
            case (state_q)
                PS_IDLE: begin
                    if (in_req) begin
                        if (routed_q) begin
                            state_q <= PS_FWD;
                            fwd_q   <= 1'b1;
                            clr_q   <= is_clr;
                        end else if (is_dir) begin
                            if (granted) begin
                                state_q  <= PS_DONE;
                                routed_q <= 1'b1;
                                dst_q    <= code[IDX_W-1:0];
                                fwd_q    <= 1'b0;
                            end
                        end else begin
                            state_q <= PS_DONE;
                            fwd_q   <= 1'b0;
                        end
                    end
                end
                PS_FWD: begin
                    if (dest_ack) state_q <= PS_DONE;
                end
                PS_DONE: begin
                    if (done_ok) begin
                        state_q <= PS_IDLE;
                        if (clr_q) begin
                            routed_q <= 1'b0;
                            clr_q    <= 1'b0;
                        end
                    end
                end
                default: state_q <= PS_IDLE;
            endcase
        end
    end

    assign in_ack    = (state_q == PS_DONE);
    assign fwd_valid = (state_q == PS_FWD);
    assign route_dst = dst_q;

    p_ack_after_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ack) |-> $past(in_req));

    p_ack_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ack && in_req) |=> in_ack);

    p_stall_no_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|claim && !granted) |=> !in_ack);
endmodule

// File: rtl/wh_switch.sv
// Five-port wormhole switch top.
// It builds one controller per input and one locking arbiter per output,
// and forwards the symbol of each output's owner.
// Assumes: direction command code k selects output k.
module wh_switch #(
    parameter int NPORT = 5,
    parameter int SYM_W = 5,
    localparam int IDX_W = $clog2(NPORT),
    localparam int BUS_W = NPORT * SYM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPORT-1:0] in_req,
    input  logic [BUS_W-1:0] in_sym,
    output logic [NPORT-1:0] in_ack,
    output logic [NPORT-1:0] out_req,
    output logic [BUS_W-1:0] out_sym,
    input  logic [NPORT-1:0] out_ack
);
    logic [NPORT-1:0] claim_i  [NPORT];   // by input, bit per output
    logic [NPORT-1:0] grant_o  [NPORT];   // by output, bit per input
    logic [NPORT-1:0] grant_i  [NPORT];   // by input, bit per output
    logic [NPORT-1:0] req_o    [NPORT];   // by output, bit per input
    logic [NPORT-1:0] rel_o    [NPORT];   // by output, bit per input
    logic [NPORT-1:0] drive_o  [NPORT];   // by output, bit per input
    logic [NPORT-1:0] dst_hot  [NPORT];   // by input, one-hot destination
    logic [IDX_W-1:0] dst_i    [NPORT];
    logic [NPORT-1:0] fwd_i;
    logic [NPORT-1:0] rel_i;
    logic [NPORT-1:0] dack_i;
    logic [NPORT-1:0] locked_o;

    // destination decode per input
    always_comb begin
        for (int i = 0; i < NPORT; i++) begin
            for (int o = 0; o < NPORT; o++) begin
                dst_hot[i][o] = (dst_i[i] == IDX_W'(o));
            end
            dack_i[i] = |(out_ack & dst_hot[i]);
        end
    end

    // transpose input-side and output-side matrices
    always_comb begin
        for (int o = 0; o < NPORT; o++) begin
            for (int i = 0; i < NPORT; i++) begin
                req_o[o][i]   = claim_i[i][o];
                grant_i[i][o] = grant_o[o][i];
                rel_o[o][i]   = rel_i[i] && dst_hot[i][o];
                drive_o[o][i] = fwd_i[i] && dst_hot[i][o];
            end
        end
    end

    // output request and symbol mux
    always_comb begin
        out_sym = '0;
        for (int o = 0; o < NPORT; o++) begin
            out_req[o] = |drive_o[o];
            for (int i = 0; i < NPORT; i++) begin
                if (drive_o[o][i]) begin
                    out_sym[o*SYM_W +: SYM_W] = out_sym[o*SYM_W +: SYM_W]
                                                | in_sym[i*SYM_W +: SYM_W];
                end
            end
        end
    end

    for (genvar gi = 0; gi < NPORT; gi++) begin : g_in
        wh_in_port #(.NPORT(NPORT), .SYM_W(SYM_W)) u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_req    (in_req[gi]),
            .in_sym    (in_sym[gi*SYM_W +: SYM_W]),
            .in_ack    (in_ack[gi]),
            .grant     (grant_i[gi]),
            .dest_ack  (dack_i[gi]),
            .claim     (claim_i[gi]),
            .fwd_valid (fwd_i[gi]),
            .route_dst (dst_i[gi]),
            .release_o (rel_i[gi])
        );
    end

    for (genvar go = 0; go < NPORT; go++) begin : g_out
        wh_out_lock #(.NPORT(NPORT)) u_lock (
            .clk    (clk),
            .rst_n  (rst_n),
            .req    (req_o[go]),
            .rel    (rel_o[go]),
            .grant  (grant_o[go]),
            .locked (locked_o[go])
        );

        p_single_driver_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(drive_o[go]));

        p_owner_drives_r8: assert property (@(posedge clk) disable iff (!rst_n)
            out_req[go] |-> locked_o[go]);

        p_wait_downstream_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (out_req[go] && !out_ack[go]) |=> out_req[go]);
    end
endmodule

// File: tb/tb_wh_switch.sv
module tb_wh_switch;
    localparam int NP = 5;
    localparam int SW = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NP-1:0]   in_req = '0;
    logic [NP*SW-1:0] in_sym = '0;
    logic [NP-1:0]   in_ack;
    logic [NP-1:0]   out_req;
    logic [NP*SW-1:0] out_sym;
    logic [NP-1:0]   out_ack = '0;

    logic [NP-1:0]   sink_en = '1;
    logic [SW-1:0]   rx_last [NP];
    int              rx_cnt  [NP];
    int              n_chk = 0;
    int              n_err = 0;
    bit              done = 1'b0;

    wh_switch #(.NPORT(NP), .SYM_W(SW)) dut (
        .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_sym(in_sym),
        .in_ack(in_ack), .out_req(out_req), .out_sym(out_sym), .out_ack(out_ack)
    );

    always #10 clk = ~clk;

    // downstream receivers: capture and acknowledge on falling edges
    initial begin
        for (int o = 0; o < NP; o++) begin rx_cnt[o] = 0; rx_last[o] = '0; end
        forever begin
            @(negedge clk);
            for (int o = 0; o < NP; o++) begin
                if (out_req[o] && !out_ack[o] && sink_en[o]) begin
                    rx_last[o] = out_sym[o*SW +: SW];
                    rx_cnt[o]  = rx_cnt[o] + 1;
                    out_ack[o] = 1'b1;
                end else if (!out_req[o]) begin
                    out_ack[o] = 1'b0;
                end
            end
        end
    end

    function automatic logic [SW-1:0] cmd(input int c);
        return {1'b1, 4'(c)};
    endfunction

    function automatic logic [SW-1:0] dat(input int n);
        return {1'b0, 4'(n)};
    endfunction

    function automatic int rx_total();
        int t = 0;
        for (int o = 0; o < NP; o++) t += rx_cnt[o];
        return t;
    endfunction

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    // four-phase send; lat = falling edges from request to acknowledge
    task automatic send(input int p, input logic [SW-1:0] s, output int lat);
        int w;
        @(negedge clk);
        in_sym[p*SW +: SW] = s;
        in_req[p] = 1'b1;
        lat = 0;
        while (!in_ack[p] && lat < 300) begin @(negedge clk); lat++; end
        in_req[p] = 1'b0;
        w = 0;
        while (in_ack[p] && w < 300) begin @(negedge clk); w++; end
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            finish_sim();
        end
    end

    initial begin
        int l, l2, c0, t0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(in_ack == '0, "R1 in_ack after reset", int'(in_ack), 0);
        chk(out_req == '0, "R1 out_req after reset", int'(out_req), 0);

        // sweep every input/output pair (R2 encoding: cmd k routes to port k, 5 clears)
        for (int i = 0; i < NP; i++) begin
            for (int o = 0; o < NP; o++) begin
                int j = (i + 1) % NP;
                int nb = (i * 5 + o + 3) & 15;
                c0 = rx_cnt[o];
                send(i, cmd(o), l);
                chk(l == 2, "R3 setup ack latency", l, 2);
                chk(rx_cnt[o] == c0, "R3 setup consumed", rx_cnt[o], c0);
                send(i, dat(nb), l);
                chk(l == 2, "R4 forward ack latency", l, 2);
                chk(rx_last[o] == dat(nb), "R4 forwarded symbol", int'(rx_last[o]), int'(dat(nb)));
                send(i, cmd((o + 1) % NP), l);
                chk(rx_last[o] == cmd((o + 1) % NP), "R5 direction as payload",
                    int'(rx_last[o]), int'(cmd((o + 1) % NP)));
                chk(rx_cnt[o] == c0 + 2, "R5 route unchanged", rx_cnt[o], c0 + 2);
                send(i, cmd(5), l);
                chk(rx_last[o] == cmd(5), "R6 clear forwarded", int'(rx_last[o]), int'(cmd(5)));
                t0 = rx_total();
                send(i, dat(nb), l);
                chk(l == 1, "R11 unrouted data latency", l, 1);
                chk(rx_total() == t0, "R6 route released", rx_total(), t0);
                send(j, cmd(o), l);
                chk(l == 2, "R6 output reclaimable", l, 2);
                send(j, cmd(5), l);
            end
        end

        // R7 persistence over several symbols
        c0 = rx_cnt[3];
        send(0, cmd(3), l);
        for (int k = 0; k < 6; k++) begin
            send(0, dat(k + 7), l);
            chk(rx_last[3] == dat(k + 7), "R7 symbol on held route", int'(rx_last[3]), int'(dat(k + 7)));
        end
        chk(rx_cnt[3] == c0 + 6, "R7 count on held route", rx_cnt[3], c0 + 6);
        send(0, cmd(5), l);

        // R8 crossing traffic
        send(0, cmd(2), l);
        send(1, cmd(3), l);
        fork
            send(0, dat(10), l);
            send(1, dat(5), l2);
        join
        chk(l == 2 && l2 == 2, "R8 concurrent latency", l * 10 + l2, 22);
        chk(rx_last[2] == dat(10), "R8 symbol west", int'(rx_last[2]), int'(dat(10)));
        chk(rx_last[3] == dat(5), "R8 symbol south", int'(rx_last[3]), int'(dat(5)));
        fork
            send(0, cmd(5), l);
            send(1, cmd(5), l2);
        join

        // R9 contention stall and hand-over
        send(0, cmd(4), l);
        fork
            send(1, cmd(4), l2);
            begin
                repeat (6) @(negedge clk);
                chk(in_ack[1] == 1'b0, "R9 stalled ack low", int'(in_ack[1]), 0);
                send(0, cmd(5), l);
            end
        join
        chk(l2 == 11, "R9 waiter latency", l2, 11);
        send(1, cmd(5), l);
        chk(rx_last[4] == cmd(5), "R9 new owner clear", int'(rx_last[4]), int'(cmd(5)));

        // R10 simultaneous requests, lowest index wins
        fork
            begin
                send(2, cmd(1), l);
                send(2, cmd(5), l);
            end
            send(3, cmd(1), l2);
        join
        chk(l2 == 9, "R10 loser waits", l2, 9);
        send(3, dat(9), l);
        chk(rx_last[1] == dat(9), "R10 loser routed", int'(rx_last[1]), int'(dat(9)));
        send(3, cmd(5), l);

        // R12 downstream backpressure
        send(0, cmd(1), l);
        sink_en[1] = 1'b0;
        fork
            send(0, dat(12), l);
            begin
                repeat (5) @(negedge clk);
                chk(in_ack[0] == 1'b0, "R12 ack held low", int'(in_ack[0]), 0);
                chk(out_req[1] == 1'b1, "R12 request held", int'(out_req[1]), 1);
                sink_en[1] = 1'b1;
            end
        join
        chk(rx_last[1] == dat(12), "R12 delivered after release", int'(rx_last[1]), int'(dat(12)));
        send(0, cmd(5), l);

        // R11 unrouted non-direction symbols consumed
        t0 = rx_total();
        send(2, cmd(9), l);
        chk(l == 1, "R11 plain command latency", l, 1);
        send(2, cmd(5), l);
        chk(l == 1, "R11 unrouted clear latency", l, 1);
        send(4, dat(3), l);
        chk(l == 1, "R11 unrouted data latency", l, 1);
        chk(rx_total() == t0, "R11 nothing forwarded", rx_total(), t0);

        done = 1'b1;
        finish_sim();
    end
endmodule